// File: doc/BRIEF.md
# One-Time-Programmable Memory Byte Writer

This block sits on the programmer side of a one-time-programmable 8051-class device and burns one byte per command. A command names a target region, an address and a data byte. For each command the block presents the address, then the data, then the control-pin pattern for the region. It then turns on the programming-voltage enable and sends a train of active-low programming pulses. After the train it lowers the voltage and holds the buses. If the command asks for it and the target is the code array, the block also reads the byte back and compares it.

All intervals come from one reference clock. Microsecond intervals scale with a clocks-per-microsecond parameter. Intervals given in device clock periods scale with a reference-clocks-per-device-period parameter. The analog programming supply is reduced to a single enable output. A verify mismatch sets a sticky error flag, and the address of the first failing byte is kept until reset.

Top module: `eprom_prog_seq`

## Requirements
- R1: Reset state. After synchronous reset `prog_n` is 1, `vpp_en` is 0, `cmd_ready` is 1, `data_oe` is 0, `mode_sel` is 5'b00000, `done` is 0 and `err_flag` is 0.
- R2: Command acceptance and bus order. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1.
  - `addr_o` takes the address on that same edge.
  - `data_o` and `data_oe`=1 follow one edge later.
  - `mode_sel` takes the region pattern one edge after that.
- R3: Setup before the first pulse. The first low cycle of `prog_n` comes at least SETUP_DEV device periods after the address was applied.
- R4: Programming-voltage window. `vpp_en` rises after the pins are set and stays 1 for at least VPP_US microseconds before the first pulse. It stays 1 through the whole train. It falls no sooner than VPP_US microseconds after the last pulse ends.
- R5: Pulse count per region. The code array gets exactly 5 pulses per byte. The encryption table and each lock bit get exactly 25.
- R6: Pulse shape. Each `prog_n` low phase lasts between 90 and 110 microseconds (PULSE_US). Consecutive pulses are separated by at least GAP_US microseconds high.
- R7: Address and data hold. `addr_o` stays constant for the whole command. `data_o` stays constant while `data_oe` is 1. `data_oe` stays 1 for at least SETUP_DEV device periods after the last pulse ends.
- R8: Region pin patterns. `mode_sel` is written MSB first, in the order of the five device control pins.
  - The `cmd_region` codes map as follows: 0 code array → 5'b01111, 1 encryption table → 5'b01101, 2 lock bit 1 → 5'b11111, 3 lock bit 2 → 5'b11100, 4 lock bit 3 → 5'b10110.
  - Codes 5 to 7 are handled as the code array.
  - Pulses occur only under a programming pattern.
- R9: Verify read.
  - Entry: with `cmd_verify`=1 on a code-array command, `vpp_en` is already 0 and `data_oe` goes to 0 when `mode_sel` becomes 5'b00011.
  - Sampling: `rd_data` is sampled VFY_DEV device periods after that pattern appears, and compared with the programmed byte.
- R10: Completion flag. `done` is a one-cycle pulse at the end of each command. `pass` is 1 unless a verify read mismatched.
- R11: Error latch. A verify mismatch sets `err_flag`, which holds until reset. `err_addr` holds the address of the first mismatch; later mismatches do not change it.
- R12: Verify on other regions. For regions other than the code array, `cmd_verify` is ignored: no verify pattern appears, `pass` is 1 and `err_flag` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_region | input | 3 | Target region code |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Byte to program |
| cmd_verify | input | 1 | Request read-back compare |
| addr_o | output | ADDR_W | Address bus to the device |
| data_o | output | 8 | Data bus driven to the device |
| data_oe | output | 1 | Data bus drive enable |
| rd_data | input | 8 | Data bus read from the device |
| mode_sel | output | 5 | Control-pin pattern |
| vpp_en | output | 1 | Programming-voltage enable |
| prog_n | output | 1 | Active-low programming pulse |
| done | output | 1 | One-cycle end-of-command strobe |
| pass | output | 1 | Result of the last command |
| err_flag | output | 1 | Sticky verify-mismatch flag |
| err_addr | output | ADDR_W | Address of the first mismatch |

## Verification
The bound assertions check the following on every cycle:
- the reset state;
- that `vpp_en` is on whenever `prog_n` is low;
- that the buses hold steady during a pulse;
- that a programming pattern is present during a pulse;
- that the verify pattern never appears with the voltage on or the data bus driven;
- that the error flag and its address stay latched;
- that `done` lasts one cycle.

Only the bench scenarios can show the remaining behaviour. That covers pulse counts per region, low widths and gaps in microseconds, and the setup and hold distances in cycles. It also covers the one-edge bus order and the region pin codes. Finally, it covers that the verify sample waits for the read window: its device model returns wrong data until then.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  // control-pin patterns, MSB first
  localparam logic [4:0] SEL_IDLE  = 5'b00000;
  localparam logic [4:0] SEL_CODE  = 5'b01111;
  localparam logic [4:0] SEL_CRYPT = 5'b01101;
  localparam logic [4:0] SEL_LOCK1 = 5'b11111;
  localparam logic [4:0] SEL_LOCK2 = 5'b11100;
  localparam logic [4:0] SEL_LOCK3 = 5'b10110;
  localparam logic [4:0] SEL_VFY   = 5'b00011;

  typedef enum logic [3:0] {
    S_IDLE, S_DATA, S_PINS, S_SETUP, S_VPP, S_LOW,
    S_HIGH, S_VHOLD, S_AHOLD, S_VFY, S_DONE
  } seq_state_e;

  function automatic logic is_code(input logic [2:0] rgn);
    return (rgn == 3'd0) || (rgn > 3'd4);
  endfunction

  function automatic logic [4:0] sel_for(input logic [2:0] rgn);
    case (rgn)
      3'd1:    return SEL_CRYPT;
      3'd2:    return SEL_LOCK1;
      3'd3:    return SEL_LOCK2;
      3'd4:    return SEL_LOCK3;
      default: return SEL_CODE;
    endcase
  endfunction

endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pps_pulse_cnt.sv
module pps_pulse_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)                      left <= '0;
    else if (load)                left <= num;
    else if (dec && left != '0)   left <= left - 1'b1;
  end

  assign last = (left == W'(1));
endmodule

// File: rtl/pps_verify.sv
module pps_verify #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [7:0]        exp_data,
  input  logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] addr,
  output logic              mismatch,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr
);
  assign mismatch = (rd_data != exp_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      err_addr <= '0;
    end else if (strobe && mismatch && !err_flag) begin
      err_flag <= 1'b1;
      err_addr <= addr;
    end
  end
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int CLK_PER_US  = 2,
  parameter int DEV_DIV     = 1,
  parameter int PULSE_US    = 100,
  parameter int GAP_US      = 10,
  parameter int VPP_US      = 10,
  parameter int SETUP_DEV   = 48,
  parameter int VFY_DEV     = 48,
  parameter int CODE_PULSES = 5,
  parameter int AUX_PULSES  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_region,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              cmd_verify,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o,
  output logic              data_oe,
  input  logic [7:0]        rd_data,
  output logic [4:0]        mode_sel,
  output logic              vpp_en,
  output logic              prog_n,
  output logic              done,
  output logic              pass,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr
);
  localparam int PULSE_CYC = PULSE_US * CLK_PER_US;
  localparam int GAP_CYC   = GAP_US * CLK_PER_US;
  localparam int VPP_CYC   = VPP_US * CLK_PER_US;
  localparam int SETUP_CYC = SETUP_DEV * DEV_DIV;
  localparam int HOLD_CYC  = SETUP_DEV * DEV_DIV;
  localparam int VFY_CYC   = VFY_DEV * DEV_DIV;
  localparam int MAX_A     = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int MAX_B     = (VPP_CYC > SETUP_CYC) ? VPP_CYC : SETUP_CYC;
  localparam int MAX_AB    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC   = (MAX_AB > VFY_CYC) ? MAX_AB : VFY_CYC;
  localparam int TMR_W     = $clog2(MAX_CYC + 1);
  localparam int MAX_PUL   = (AUX_PULSES > CODE_PULSES) ? AUX_PULSES : CODE_PULSES;
  localparam int PC_W      = $clog2(MAX_PUL + 1);

  seq_state_e st, nxt;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             pc_load, pc_dec, pc_last;
  logic [PC_W-1:0]  pc_num;
  logic             vstrobe, mismatch;
  logic [7:0]       dat_q;
  logic [2:0]       rgn_q;
  logic             vfy_q;

  pps_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  assign pc_num = is_code(cmd_region) ? PC_W'(CODE_PULSES) : PC_W'(AUX_PULSES);

  pps_pulse_cnt #(.W(PC_W)) u_pc (
    .clk(clk), .rst(rst), .load(pc_load), .num(pc_num), .dec(pc_dec), .last(pc_last)
  );

  pps_verify #(.ADDR_W(ADDR_W)) u_vfy (
    .clk(clk), .rst(rst), .strobe(vstrobe), .exp_data(data_o), .rd_data(rd_data),
    .addr(addr_o), .mismatch(mismatch), .err_flag(err_flag), .err_addr(err_addr)
  );

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    pc_load  = 1'b0;
    pc_dec   = 1'b0;
    vstrobe  = 1'b0;
    case (st)
      S_IDLE: if (cmd_valid) begin
        nxt     = S_DATA;
        pc_load = 1'b1;
      end
      S_DATA: nxt = S_PINS;
      S_PINS: begin
        nxt = S_SETUP; tmr_load = 1'b1; tmr_val = TMR_W'(SETUP_CYC - 1);
      end
      S_SETUP: if (tmr_zero) begin
        nxt = S_VPP; tmr_load = 1'b1; tmr_val = TMR_W'(VPP_CYC - 1);
      end
      S_VPP: if (tmr_zero) begin
        nxt = S_LOW; tmr_load = 1'b1; tmr_val = TMR_W'(PULSE_CYC - 1);
      end
      S_LOW: if (tmr_zero) begin
        pc_dec   = 1'b1;
        tmr_load = 1'b1;
        if (pc_last) begin
          nxt = S_VHOLD; tmr_val = TMR_W'(VPP_CYC - 1);
        end else begin
          nxt = S_HIGH;  tmr_val = TMR_W'(GAP_CYC - 1);
        end
      end
      S_HIGH: if (tmr_zero) begin
        nxt = S_LOW; tmr_load = 1'b1; tmr_val = TMR_W'(PULSE_CYC - 1);
      end
      S_VHOLD: if (tmr_zero) begin
        nxt = S_AHOLD; tmr_load = 1'b1; tmr_val = TMR_W'(HOLD_CYC - 1);
      end
      S_AHOLD: if (tmr_zero) begin
        if (vfy_q) begin
          nxt = S_VFY; tmr_load = 1'b1; tmr_val = TMR_W'(VFY_CYC - 1);
        end else begin
          nxt = S_DONE;
        end
      end
      S_VFY: if (tmr_zero) begin
        nxt = S_DONE; vstrobe = 1'b1;
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cmd_ready <= 1'b1;
      addr_o    <= '0;
      data_o    <= '0;
      data_oe   <= 1'b0;
      mode_sel  <= SEL_IDLE;
      vpp_en    <= 1'b0;
      prog_n    <= 1'b1;
      done      <= 1'b0;
      pass      <= 1'b0;
      dat_q     <= '0;
      rgn_q     <= '0;
      vfy_q     <= 1'b0;
    end else begin
      st   <= nxt;
      done <= 1'b0;
      if (nxt != st) begin
        case (nxt)
          S_DATA: begin
            cmd_ready <= 1'b0;
            addr_o    <= cmd_addr;
            dat_q     <= cmd_data;
            rgn_q     <= cmd_region;
            vfy_q     <= cmd_verify && is_code(cmd_region);
          end
          S_PINS: begin
            data_o  <= dat_q;
            data_oe <= 1'b1;
          end
          S_SETUP: mode_sel <= sel_for(rgn_q);
          S_VPP:   vpp_en   <= 1'b1;
          S_LOW:   prog_n   <= 1'b0;
          S_HIGH,
          S_VHOLD: prog_n   <= 1'b1;
          S_AHOLD: vpp_en   <= 1'b0;
          S_VFY: begin
            mode_sel <= SEL_VFY;
            data_oe  <= 1'b0;
          end
          S_DONE: begin
            done     <= 1'b1;
            pass     <= vfy_q ? !mismatch : 1'b1;
            data_oe  <= 1'b0;
            mode_sel <= SEL_IDLE;
          end
          S_IDLE:  cmd_ready <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] addr_o,
  input logic [7:0]        data_o,
  input logic              data_oe,
  input logic [4:0]        mode_sel,
  input logic              vpp_en,
  input logic              prog_n,
  input logic              done,
  input logic              err_flag,
  input logic [ADDR_W-1:0] err_addr
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (prog_n && !vpp_en && cmd_ready && !data_oe && !err_flag && !done));

  // R4
  a_r4_pulse_under_vpp: assert property (@(posedge clk) disable iff (rst)
    !prog_n |-> vpp_en);

  // R7
  a_r7_bus_held_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !prog_n |-> (data_oe && $stable(addr_o) && $stable(data_o)));

  // R8
  a_r8_pulse_has_pattern: assert property (@(posedge clk) disable iff (rst)
    !prog_n |-> (mode_sel != SEL_IDLE && mode_sel != SEL_VFY));

  // R9
  a_r9_verify_unpowered: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == SEL_VFY) |-> (!vpp_en && !data_oe && prog_n));

  // R10
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  a_r11_err_latched: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> (err_flag && $stable(err_addr)));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .addr_o(addr_o), .data_o(data_o),
  .data_oe(data_oe), .mode_sel(mode_sel), .vpp_en(vpp_en), .prog_n(prog_n),
  .done(done), .err_flag(err_flag), .err_addr(err_addr)
);

// File: tb/eprom_prog_seq_tb_top.sv
module eprom_prog_seq_tb_top;
  localparam int T_US    = 2;
  localparam int SETUP_N = 48;
  localparam int VFY_N   = 48;
  localparam logic [4:0] P_VFY = 5'b00011;

  typedef struct {
    logic [2:0]  rgn;
    logic [14:0] addr;
    logic [7:0]  data;
    bit          vfy;
    bit          pass;
    int          pulses;
    logic [4:0]  pat;
    bit          err;
    logic [14:0] eaddr;
  } item_t;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_verify = 1'b0;
  logic [2:0]  cmd_region = '0;
  logic [14:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        cmd_ready, data_oe, vpp_en, prog_n, done, pass, err_flag;
  logic [14:0] addr_o, err_addr;
  logic [7:0]  data_o, rd_data;
  logic [4:0]  mode_sel;

  item_t q[$];
  int    n_chk = 0, n_bad = 0;
  bit    finished = 0;
  logic [7:0] cur_data = '0, cur_fault = '0;
  int    vcnt = 0;
  bit    b_err = 0;
  logic [14:0] b_eaddr = '0;

  always #4 clk = ~clk;

  eprom_prog_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_region(cmd_region), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_verify(cmd_verify), .addr_o(addr_o), .data_o(data_o), .data_oe(data_oe),
    .rd_data(rd_data), .mode_sel(mode_sel), .vpp_en(vpp_en), .prog_n(prog_n),
    .done(done), .pass(pass), .err_flag(err_flag), .err_addr(err_addr)
  );

  // device model: read data valid only after the verify window
  always_ff @(posedge clk) vcnt <= (mode_sel == P_VFY) ? vcnt + 1 : 0;
  assign rd_data = (mode_sel == P_VFY && vcnt >= VFY_N - 1) ? (cur_data ^ cur_fault) : ~cur_data;

  function automatic logic [4:0] pat_of(input logic [2:0] r);
    case (r)
      3'd1: return 5'b01101;
      3'd2: return 5'b11111;
      3'd3: return 5'b11100;
      3'd4: return 5'b10110;
      default: return 5'b01111;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] r, input logic [14:0] a, input logic [7:0] d,
                      input bit v, input logic [7:0] fault);
    item_t it;
    bit code;
    code      = (r == 3'd0) || (r > 3'd4);
    it.rgn    = r;  it.addr = a;  it.data = d;
    it.vfy    = v && code;
    it.pass   = !(it.vfy && fault != 8'h00);
    it.pulses = code ? 5 : 25;
    it.pat    = pat_of(r);
    if (!it.pass && !b_err) begin b_err = 1; b_eaddr = a; end
    it.err    = b_err;
    it.eaddr  = b_eaddr;
    q.push_back(it);
    cur_data  = d;
    cur_fault = fault;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_region = r; cmd_addr = a; cmd_data = d; cmd_verify = v;
    @(negedge clk);
    cmd_valid = 0;
    wait (q.size() == 0);
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    bit act = 0, prev_ready = 0, prev_prog = 1, prev_vpp = 0, prev_oe = 0;
    bit bus_bad = 0, vfy_seen = 0;
    int ph = 0, npulse = 0, lowlen = 0, gaplen = 0, vpp_run = 0, since_rise = 0, hold_cnt = 0;
    forever begin
      @(posedge clk); #2;
      if (rst) begin
        prev_ready = 0; act = 0;
        continue;
      end
      if (!act && prev_ready && cmd_valid) begin
        act = 1; it = q[0]; ph = 0; npulse = 0; bus_bad = 0; vfy_seen = 0;
        lowlen = 0; gaplen = 0; vpp_run = 0; since_rise = 0; hold_cnt = 0;
      end else if (act) ph++;
      if (act) begin
        if (ph == 0) chk(addr_o == it.addr && !data_oe && mode_sel == 5'b0, "R2 address first", addr_o, it.addr);
        if (ph == 1) chk(data_oe && data_o == it.data && mode_sel == 5'b0, "R2 data second", data_o, it.data);
        if (ph == 2) chk(mode_sel == it.pat, "R8 region pin pattern", mode_sel, it.pat);
        if (addr_o != it.addr || (data_oe && data_o != it.data)) bus_bad = 1;
        if (mode_sel == P_VFY) vfy_seen = 1;
        if (prev_prog && !prog_n) begin
          npulse++;
          if (npulse == 1) begin
            chk(ph >= SETUP_N, "R3 setup before first pulse", ph, SETUP_N);
            chk(vpp_run >= 10 * T_US, "R4 voltage lead", vpp_run, 10 * T_US);
          end else
            chk(gaplen >= 10 * T_US, "R6 gap between pulses", gaplen, 10 * T_US);
          lowlen = 0;
        end
        if (!prev_prog && prog_n) begin
          chk(lowlen >= 90 * T_US && lowlen <= 110 * T_US, "R6 pulse low width", lowlen, 100 * T_US);
          gaplen = 0; since_rise = 0; hold_cnt = 0;
        end
        if (prev_vpp && !vpp_en) begin
          chk(since_rise >= 10 * T_US, "R4 voltage hold after last pulse", since_rise, 10 * T_US);
          chk(npulse == it.pulses, "R4 voltage kept through train", npulse, it.pulses);
        end
        if (prev_oe && !data_oe && npulse > 0)
          chk(hold_cnt >= SETUP_N, "R7 data hold after last pulse", hold_cnt, SETUP_N);
        if (done) begin
          chk(npulse == it.pulses, "R5 pulse count", npulse, it.pulses);
          chk(vfy_seen == it.vfy, it.vfy ? "R9 verify performed" : "R12 verify skipped", vfy_seen, it.vfy);
          chk(pass == it.pass, "R10 pass flag", pass, it.pass);
          chk(err_flag == it.err, "R11 error flag", err_flag, it.err);
          if (it.err) chk(err_addr == it.eaddr, "R11 first failing address", err_addr, it.eaddr);
          chk(!bus_bad, "R7 address and data held", bus_bad, 0);
          void'(q.pop_front());
          act = 0;
        end
        if (!prog_n) lowlen++; else gaplen++;
        if (vpp_en && prog_n) vpp_run++; else if (!vpp_en) vpp_run = 0;
        if (vpp_en && prog_n) since_rise++;
        hold_cnt++;
      end
      prev_ready = cmd_ready; prev_prog = prog_n; prev_vpp = vpp_en; prev_oe = data_oe;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(prog_n == 1 && vpp_en == 0, "R1 reset pulse and voltage idle", {prog_n, vpp_en}, 2'b10);
    chk(cmd_ready == 1 && data_oe == 0, "R1 reset ready and bus off", {cmd_ready, data_oe}, 2'b10);
    chk(mode_sel == 5'b0 && done == 0 && err_flag == 0, "R1 reset pins and flags", mode_sel, 0);
    send(3'd0, 15'h0123, 8'hA5, 1, 8'h00);   // code, verify passes
    send(3'd0, 15'h7FFF, 8'h3C, 1, 8'h10);   // code, verify fails
    send(3'd0, 15'h0042, 8'h00, 0, 8'h00);   // code, no verify
    send(3'd1, 15'h0005, 8'h5A, 1, 8'hFF);   // encryption, verify ignored
    send(3'd2, 15'h0000, 8'hFF, 0, 8'h00);   // lock bit 1
    send(3'd3, 15'h0000, 8'hFF, 1, 8'h01);   // lock bit 2, verify ignored
    send(3'd4, 15'h0000, 8'hFF, 0, 8'h00);   // lock bit 3
    send(3'd0, 15'h0100, 8'hFF, 1, 8'h01);   // second mismatch keeps first address
    send(3'd0, 15'h0200, 8'hC3, 1, 8'h00);   // verify passes after error
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule